// File: doc/BRIEF.md
# Scan-Chain Register Access Port

This block is the test-clock-side data register that lets a debug host reach a register space of 128 words, each 32 bits wide. It sits behind a TAP controller. From the controller it takes the capture, shift and update strobes, the TDI bit and a select line that is high while its instruction is loaded. It drives TDO while selected. On its far side it is a simple register-bus master: address, write data, read data, and one-cycle read and write strobes.

The chain is 40 bits long. A scan that ends in update either writes its data field to the addressed register or starts a read of that register. A read result is not returned in the same scan. It is latched from the bus and loaded into the data field at the next capture, so every read takes two scans. The host normally sends address 0 on the trailing scan of a read burst. Address 0 holds a side-effect-free identity value, so no register with read side effects is read twice.

Top module: `scan_regport`

## Requirements
- R1: Shift order: bit 0 of the 40-bit chain is nearest TDO. Bits 31:0 are data, bits 38:32 are the register address and bit 39 is the access flag. After a capture, the first 32 TDO bits are the data field, least significant bit first.
- R2: Each shift cycle moves the chain one place toward TDO and enters TDI at bit 39. Forty shifts without a capture return the previously shifted-in word unchanged.
- R3: An update with flag 1 gives, in the next cycle, a single-cycle write strobe with bits 38:32 on the address and bits 31:0 on the write data. No read strobe is given.
- R4: An update with flag 0 gives, in the next cycle, a single-cycle read strobe with bits 38:32 on the address. No write strobe is given.
- R5: The read data present during the read strobe is returned in bits 31:0 at the next capture. Bits 39:32 capture as zero.
- R6: A capture that follows no new read loads the most recent read result again.
- R7: A capture in the same cycle as the read strobe loads the read data of that cycle.
- R8: While select is low, capture, shift and update have no effect: TDO is 0, no strobe is given, and the chain contents are kept.
- R9: During and just after reset, TDO is 0, both strobes are low and the held read result is 0.
- R10: Each update yields exactly one strobe cycle; strobes never overlap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | High while this chain's instruction is selected |
| capture | input | 1 | Capture-DR strobe |
| shift | input | 1 | Shift-DR strobe |
| update | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, chain bit 0 |
| bus_addr | output | 7 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data returned by the addressed register |
| bus_wr | output | 1 | One-cycle write strobe |
| bus_rd | output | 1 | One-cycle read strobe |

## Verification
The read-return path and the capture path can act in the same cycle. This happens when a capture is driven in the cycle right after a read's update, while the read strobe is still high. The bench provokes this by issuing a read with no idle cycles after its update and capturing immediately. The next scan must then return the bus data of that strobe cycle, and not the older held result. The bench judges this against its shadow copy of the register space. The register at address 4 counts its own reads, so a doubled or missed read changes the value returned.

// File: rtl/scanport_pkg.sv
package scanport_pkg;
  localparam int DEF_DATA_W = 32;
  localparam int DEF_ADDR_W = 7;

  typedef enum logic {
    ACC_READ  = 1'b0,
    ACC_WRITE = 1'b1
  } acc_kind_e;
endpackage

// File: rtl/scanport_rstsync.sv
module scanport_rstsync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/scanport_shreg.sv
module scanport_shreg #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic         sh_en,
  input  logic         tdi,
  input  logic [W-1:0] cap_val,
  output logic [W-1:0] sr_q
);
  logic [W-1:0] sr_d;
  logic         sr_en;

  always_comb begin
    sr_d  = sr_q;
    sr_en = cap_en | sh_en;
    if (cap_en)     sr_d = cap_val;
    else if (sh_en) sr_d = {tdi, sr_q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  // R2: shift moves chain one place toward bit 0
  assert_shift_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_en && !cap_en) |=> (sr_q[W-2:0] == $past(sr_q[W-1:1])));

  // R8: without capture or shift the chain holds
  assert_chain_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !sh_en) |=> $stable(sr_q));
endmodule

// File: rtl/scanport_decode.sv
module scanport_decode #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  localparam int W = DATA_W + ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [W-1:0]      chain,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wr,
  output logic              bus_rd
);
  import scanport_pkg::*;

  acc_kind_e         kind;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d;
  logic              wr_d, rd_d;

  always_comb begin
    kind    = acc_kind_e'(chain[W-1]);
    wr_d    = upd_en && (kind == ACC_WRITE);
    rd_d    = upd_en && (kind == ACC_READ);
    addr_d  = upd_en ? chain[DATA_W +: ADDR_W] : bus_addr;
    wdata_d = wr_d ? chain[DATA_W-1:0] : bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_wr    <= 1'b0;
      bus_rd    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      bus_wr <= wr_d;
      bus_rd <= rd_d;
      if (upd_en) bus_addr  <= addr_d;
      if (wr_d)   bus_wdata <= wdata_d;
    end
  end

  // R10: strobes never overlap
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_rd));

  // R10: without a fresh update a strobe lasts one cycle
  assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && !upd_en) |=> !(bus_wr || bus_rd));

  // R3: a write strobe follows an update
  assert_wr_after_upd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |-> $past(upd_en));
endmodule

// File: rtl/scanport_rdret.sv
module scanport_rdret #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 7,
  localparam int W = DATA_W + ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [W-1:0]      cap_word
);
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] hold_d;

  always_comb begin
    hold_d   = bus_rd ? bus_rdata : hold_q;
    cap_word = {{(ADDR_W + 1){1'b0}}, hold_d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hold_q <= '0;
    else if (bus_rd) hold_q <= hold_d;
  end

  // R5: held result is the bus data seen during the strobe
  assert_hold_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (hold_q == $past(bus_rdata)));

  // R6: held result changes only through a read strobe
  assert_hold_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(hold_q));
endmodule

// File: rtl/scan_regport.sv
module scan_regport #(
  parameter int DATA_W = scanport_pkg::DEF_DATA_W,
  parameter int ADDR_W = scanport_pkg::DEF_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              capture,
  input  logic              shift,
  input  logic              update,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_wr,
  output logic              bus_rd
);
  localparam int W = DATA_W + ADDR_W + 1;

  logic         srst_n;
  logic         cap_en, sh_en, upd_en;
  logic [W-1:0] sr_q;
  logic [W-1:0] cap_word;

  always_comb begin
    cap_en = sel & capture;
    sh_en  = sel & shift & ~capture;
    upd_en = sel & update;
    tdo    = sel & sr_q[0];
  end

  scanport_rstsync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  scanport_shreg #(.W(W)) u_shreg (
    .clk     (clk),
    .rst_n   (srst_n),
    .cap_en  (cap_en),
    .sh_en   (sh_en),
    .tdi     (tdi),
    .cap_val (cap_word),
    .sr_q    (sr_q)
  );

  scanport_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_decode (
    .clk       (clk),
    .rst_n     (srst_n),
    .upd_en    (upd_en),
    .chain     (sr_q),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd)
  );

  scanport_rdret #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rdret (
    .clk       (clk),
    .rst_n     (srst_n),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .cap_word  (cap_word)
  );

  // R8: deselected chain issues no strobe
  assert_unsel_quiet_R8: assert property (@(posedge clk) disable iff (!srst_n)
    !sel |=> !(bus_wr || bus_rd));

  // R5, R1: captured upper bits are zero
  assert_cap_upper_zero_R5: assert property (@(posedge clk) disable iff (!srst_n)
    cap_en |=> (sr_q[W-1:DATA_W] == '0));
endmodule

// File: tb/scan_regport_bench.sv
module scan_regport_bench;
  localparam int CLK_P  = 10;
  localparam int DW     = 32;
  localparam int AW     = 7;
  localparam int CW     = DW + AW + 1;
  localparam logic [DW-1:0] ID_VAL = 32'h5CA7_0001;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel, capture, shift, update, tdi;
  logic          tdo;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          bus_wr, bus_rd;

  always #(CLK_P/2) clk = ~clk;

  scan_regport u_scan_regport (
    .clk(clk), .rst_n(rst_n), .sel(sel), .capture(capture), .shift(shift),
    .update(update), .tdi(tdi), .tdo(tdo), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_wr(bus_wr), .bus_rd(bus_rd)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] init_val(input int i);
    return (i * 32'h0101_0101) ^ 32'hA500_0000;
  endfunction

  // Register space model behind the bus; address 4 counts its reads
  logic [DW-1:0] mem [128];
  logic [DW-1:0] rd_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) mem[i] <= init_val(i);
      rd_cnt <= 32'h0000_0100;
    end else begin
      if (bus_wr && bus_addr != 0) mem[bus_addr] <= bus_wdata;
      if (bus_rd && bus_addr == 4) rd_cnt <= rd_cnt + 1;
    end
  end

  always_comb begin
    if (bus_addr == 0)      bus_rdata = ID_VAL;
    else if (bus_addr == 4) bus_rdata = rd_cnt;
    else                    bus_rdata = mem[bus_addr];
  end

  // Shadow for expected values
  logic [DW-1:0] sh_mem [128];
  logic [DW-1:0] sh_cnt;
  logic [DW-1:0] exp_hold;

  function automatic logic [DW-1:0] shadow_rd(input logic [AW-1:0] a);
    if (a == 0) return ID_VAL;
    if (a == 4) return sh_cnt;
    return sh_mem[a];
  endfunction

  // Scoreboard queues
  logic [CW-1:0] exp_scan [$];
  string         exp_scan_req [$];
  logic [CW:0]   exp_bus [$];
  string         exp_bus_req [$];
  logic [CW-1:0] obs_scan;
  event          scan_done;

  // Scan monitor
  initial begin
    forever begin
      @(scan_done);
      if (exp_scan.size() == 0) check(0, "R1", {24'h0, obs_scan}, 64'h0);
      else begin
        logic [CW-1:0] e;
        string r;
        e = exp_scan.pop_front();
        r = exp_scan_req.pop_front();
        check(obs_scan == e, r, {24'h0, obs_scan}, {24'h0, e});
      end
    end
  end

  // Bus monitor
  always @(negedge clk) begin
    if (rst_n && (bus_wr || bus_rd)) begin
      logic [CW:0] act;
      act = {bus_wr, bus_rd, bus_addr, (bus_wr ? bus_wdata : bus_rdata)};
      if (bus_wr && bus_rd) check(0, "R10", {23'h0, act}, 64'h0);
      else if (exp_bus.size() == 0) check(0, "R8", {23'h0, act}, 64'h0);
      else begin
        logic [CW:0] e;
        string r;
        e = exp_bus.pop_front();
        r = exp_bus_req.pop_front();
        check(act == e, r, {23'h0, act}, {23'h0, e});
      end
    end
  end

  task automatic cap_shift(input logic [CW-1:0] din, input bit do_cap, output logic [CW-1:0] dout);
    if (do_cap) begin
      capture = 1'b1;
      @(negedge clk);
      capture = 1'b0;
    end
    for (int i = 0; i < CW; i++) begin
      shift   = 1'b1;
      tdi     = din[i];
      dout[i] = tdo;
      @(negedge clk);
    end
    shift = 1'b0;
    tdi   = 1'b0;
  endtask

  task automatic upd(input bit trail);
    update = 1'b1;
    @(negedge clk);
    update = 1'b0;
    if (trail) repeat (2) @(negedge clk);
  endtask

  // Driver: one full scan, pushing expected items
  task automatic scan(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input bit trail, input string req_cap, input string req_bus);
    logic [CW-1:0] dout;
    logic [DW-1:0] v;
    exp_scan.push_back({8'h00, exp_hold});
    exp_scan_req.push_back(req_cap);
    cap_shift({wr, a, d}, 1'b1, dout);
    obs_scan = dout;
    -> scan_done;
    @(negedge clk);
    if (wr) begin
      exp_bus.push_back({1'b1, 1'b0, a, d});
      if (a != 0) sh_mem[a] = d;
    end else begin
      v = shadow_rd(a);
      exp_bus.push_back({1'b0, 1'b1, a, v});
      exp_hold = v;
      if (a == 4) sh_cnt = sh_cnt + 1;
    end
    exp_bus_req.push_back(req_bus);
    upd(trail);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) sh_mem[i] = init_val(i);
    sh_cnt   = 32'h0000_0100;
    exp_hold = '0;
    rst_n = 1'b0; sel = 1'b0; capture = 1'b0; shift = 1'b0; update = 1'b0; tdi = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(tdo == 1'b0, "R9", {63'h0, tdo}, 64'h0);
    check(bus_wr == 1'b0 && bus_rd == 1'b0, "R9", {62'h0, bus_wr, bus_rd}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    sel = 1'b1;
    @(negedge clk);

    // R9: first capture returns zero hold; R3 write
    scan(1'b1, 7'd5, 32'hDEAD_BEEF, 1'b1, "R9", "R3");
    // R6: capture with no new read returns same hold
    scan(1'b0, 7'd5, 32'h0, 1'b1, "R6", "R4");
    // R5, R1: result of read returned
    scan(1'b0, 7'd0, 32'h0, 1'b1, "R5", "R4");
    // Side-effect register: each read counted once
    scan(1'b0, 7'd4, 32'h0, 1'b1, "R1", "R4");
    scan(1'b0, 7'd4, 32'h0, 1'b1, "R5", "R4");
    scan(1'b0, 7'd0, 32'h0, 1'b1, "R5", "R4");
    scan(1'b1, 7'd127, 32'h1234_5678, 1'b1, "R5", "R3");
    scan(1'b1, 7'd126, 32'hFFFF_FFFF, 1'b1, "R6", "R3");
    scan(1'b0, 7'd127, 32'h0, 1'b1, "R6", "R4");
    // R7: capture in the read strobe cycle
    scan(1'b0, 7'd7, 32'h0, 1'b0, "R5", "R4");
    scan(1'b0, 7'd126, 32'h0, 1'b0, "R7", "R4");
    scan(1'b0, 7'd0, 32'h0, 1'b1, "R7", "R4");
    // Write then immediate capture: hold unchanged
    scan(1'b1, 7'd9, 32'h0BAD_F00D, 1'b0, "R5", "R3");
    scan(1'b0, 7'd9, 32'h0, 1'b1, "R6", "R4");
    // Shift-only pass after a known shift-in (R2), with deselected activity (R8)
    scan(1'b1, 7'd0, 32'hC0DE_0042, 1'b1, "R5", "R3");
    sel = 1'b0;
    capture = 1'b1; @(negedge clk);
    check(tdo == 1'b0, "R8", {63'h0, tdo}, 64'h0);
    capture = 1'b0;
    for (int i = 0; i < 12; i++) begin
      shift = 1'b1; tdi = i[0];
      @(negedge clk);
      check(tdo == 1'b0, "R8", {63'h0, tdo}, 64'h0);
    end
    shift = 1'b0;
    update = 1'b1; @(negedge clk); update = 1'b0;
    repeat (2) @(negedge clk);
    sel = 1'b1;
    begin
      logic [CW-1:0] dout;
      exp_scan.push_back({1'b1, 7'd0, 32'hC0DE_0042});
      exp_scan_req.push_back("R2");
      cap_shift({CW{1'b0}}, 1'b0, dout);
      obs_scan = dout;
      -> scan_done;
      @(negedge clk);
    end
    scan(1'b0, 7'd0, 32'h0, 1'b1, "R6", "R4");
    scan(1'b0, 7'd0, 32'h0, 1'b1, "R5", "R4");
    repeat (4) @(negedge clk);
    // R10: every expected strobe was seen exactly once
    check(exp_bus.size() == 0, "R10", 64'(exp_bus.size()), 64'h0);
    check(exp_scan.size() == 0, "R1", 64'(exp_scan.size()), 64'h0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule